// File: doc/BRIEF.md
# Four-Channel Match Timer with Watchdog

This block is a system timer for an operating system. A 32-bit counter moves up by one on every clock cycle in which an external tick strobe is high. Four 32-bit compare registers sit beside it. When a tick moves the counter onto a compare value, that channel records an event. If the channel's interrupt enable bit is set, the event sets a status bit, and that bit drives the channel's own interrupt line. Software sees the status through a write-one-to-clear register. Clearing a bit drops only that channel's interrupt line.

Channel 3 has a second use as a watchdog. Software can set a one-way watchdog enable. Once it is set, a channel-3 event raises a reset request, and the request stays high until the block is reset. The block does not divide its own clock. The counting rate is set entirely by how often the tick strobe is high, so one design serves platforms with different timer frequencies.

Access is through a simple register port: a byte address, write data, a write strobe and a read strobe. Read data is combinational and is valid in the same cycle as the read strobe.

Top module: `os_match_timer`

## Requirements
- R1: After reset, the counter, all compare registers, status, interrupt enable, watchdog enable, the interrupt lines and the reset request are all zero.
- R2: A write to offset 0x10 loads the counter with the written value. In a cycle without such a write, a high tick adds one (wrapping from 0xFFFFFFFF to 0), and a low tick holds the value. A load wins over a tick in the same cycle. Reads of 0x10 return the counter.
- R3: The compare register of channel n is at offset 4·n (0x00, 0x04, 0x08, 0x0C). It is 32 bits wide and can be read and written.
- R4: A channel event happens on the clock edge where a tick (not a load) moves the counter onto that channel's compare value. At that edge, if enable bit n is set, status bit n and irq_o[n] go high. If enable bit n is clear, neither changes.
- R5: Status is read at offset 0x14, bits 3:0, one bit per channel. Writing 1 to bit n clears status bit n and drops irq_o[n]. Writing 0 leaves the bit unchanged. An event in the same cycle as a clear wins, and the bit stays set.
- R6: The interrupt enable register at offset 0x1C stores bits 11:0 of the written data. Bits 31:12 read as zero. Bits 3:0 gate channels 0 to 3.
- R7: The watchdog enable is bit 0 of offset 0x18. Writing 1 sets it. Writing 0 has no effect, and only reset clears it.
- R8: A channel-3 event that occurs while the watchdog enable is already set raises rst_req_o, whatever the state of enable bit 3. Once high, rst_req_o stays high until reset.
- R9: Reads of any other offset, including any address that is not a multiple of 4, return zero, and writes to them change nothing. rdata_o is zero whenever rd_i is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-enable strobe |
| addr_i | input | 12 | Byte address of the register access |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, combinational |
| irq_o | output | 4 | Per-channel interrupt lines |
| rst_req_o | output | 1 | Sticky system reset request |

## Verification
The bench builds the block with its default parameters: a 32-bit counter, four channels, a 12-bit address and a 12-bit enable register. Because the counter is full width, the bench can load a value just below the top of the range and see a compare at zero fire across the wrap. With four channels, the enabled and disabled gating, the per-line clear and the channel-3 watchdog path can all be exercised side by side. The 12-bit enable register leaves room for stored bits above the channel bits, so the bench can check that its upper read bits stay zero.

// File: rtl/omt_pkg.sv
package omt_pkg;

    // Register offsets (byte addresses)
    localparam int unsigned OFF_COUNT  = 32'h10;
    localparam int unsigned OFF_STATUS = 32'h14;
    localparam int unsigned OFF_WDOG   = 32'h18;
    localparam int unsigned OFF_IEN    = 32'h1c;

    // Which register an access targets
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MATCH,
        SEL_COUNT,
        SEL_STATUS,
        SEL_WDOG,
        SEL_IEN
    } omt_sel_e;

endpackage

// File: rtl/omt_counter.sv
module omt_counter #(
    parameter int unsigned DW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          load_i,
    input  logic [DW-1:0] load_val_i,
    output logic [DW-1:0] cnt_o,
    output logic [DW-1:0] nxt_o,
    output logic          adv_o
);

    localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [DW-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        nxt_o = st_q.cnt + ONE;
        adv_o = tick_i && !load_i;
        if (load_i) begin
            st_d.cnt = load_val_i;
        end else if (adv_o) begin
            st_d.cnt = nxt_o;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/omt_channel.sv
module omt_channel #(
    parameter int unsigned DW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          adv_i,
    input  logic [DW-1:0] nxt_i,
    output logic [DW-1:0] match_o,
    output logic          hit_o
);

    typedef struct packed {
        logic [DW-1:0] match;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.match = wdata_i;
        end
        // event only when a tick moves the counter onto the stored value
        hit_o = adv_i && (nxt_i == st_q.match);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign match_o = st_q.match;

endmodule

// File: rtl/omt_ctrl.sv
module omt_ctrl #(
    parameter int unsigned NCH   = 4,
    parameter int unsigned IEN_W = 12,
    parameter int unsigned WD_CH = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NCH-1:0]   hit_i,
    input  logic             stat_wr_i,
    input  logic             ien_wr_i,
    input  logic             wd_wr_i,
    input  logic [IEN_W-1:0] wdata_i,
    output logic [NCH-1:0]   status_o,
    output logic [IEN_W-1:0] ien_o,
    output logic             wd_en_o,
    output logic             rst_req_o
);

    typedef struct packed {
        logic [NCH-1:0]   status;
        logic [IEN_W-1:0] ien;
        logic             wd_en;
        logic             rst_req;
    } ctrl_st_t;

    ctrl_st_t       st_d, st_q;
    logic [NCH-1:0] fire;
    logic [NCH-1:0] clr;

    always_comb begin
        st_d = st_q;
        fire = hit_i & st_q.ien[NCH-1:0];
        clr  = stat_wr_i ? wdata_i[NCH-1:0] : '0;

        // new events take precedence over a clear in the same cycle
        st_d.status = (st_q.status & ~clr) | fire;

        if (ien_wr_i) begin
            st_d.ien = wdata_i;
        end

        // one-way enable
        if (wd_wr_i && wdata_i[0]) begin
            st_d.wd_en = 1'b1;
        end

        if (st_q.wd_en && hit_i[WD_CH]) begin
            st_d.rst_req = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o  = st_q.status;
    assign ien_o     = st_q.ien;
    assign wd_en_o   = st_q.wd_en;
    assign rst_req_o = st_q.rst_req;

endmodule

// File: rtl/os_match_timer.sv
module os_match_timer #(
    parameter int unsigned DW    = 32,
    parameter int unsigned NCH   = 4,
    parameter int unsigned AW    = 12,
    parameter int unsigned IEN_W = 12
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          wr_i,
    input  logic          rd_i,
    output logic [DW-1:0] rdata_o,
    output logic [NCH-1:0] irq_o,
    output logic          rst_req_o
);

    import omt_pkg::*;

    localparam int unsigned WD_CH = NCH - 1;
    localparam int unsigned IDX_W = $clog2(NCH);
    localparam int unsigned WW    = AW - 2;

    localparam logic [WW-1:0] W_COUNT  = WW'(OFF_COUNT  >> 2);
    localparam logic [WW-1:0] W_STATUS = WW'(OFF_STATUS >> 2);
    localparam logic [WW-1:0] W_WDOG   = WW'(OFF_WDOG   >> 2);
    localparam logic [WW-1:0] W_IEN    = WW'(OFF_IEN    >> 2);
    localparam logic [WW-1:0] W_NCH    = WW'(NCH);

    omt_sel_e         sel;
    logic [IDX_W-1:0] idx;
    logic [WW-1:0]    word;

    logic             cnt_wr;
    logic             stat_wr;
    logic             ien_wr;
    logic             wd_wr;
    logic [NCH-1:0]   match_wr;

    logic [DW-1:0]    cnt;
    logic [DW-1:0]    cnt_nxt;
    logic             cnt_adv;
    logic [DW-1:0]    match_q [NCH];
    logic [NCH-1:0]   hit;
    logic [NCH-1:0]   status;
    logic [IEN_W-1:0] ien;
    logic             wd_en;
    logic [DW-1:0]    rd_val;

    // ---------------- address decode ----------------
    always_comb begin
        sel  = SEL_NONE;
        word = addr_i[AW-1:2];
        idx  = word[IDX_W-1:0];
        if (addr_i[1:0] == 2'b00) begin
            if (word < W_NCH) begin
                sel = SEL_MATCH;
            end else if (word == W_COUNT) begin
                sel = SEL_COUNT;
            end else if (word == W_STATUS) begin
                sel = SEL_STATUS;
            end else if (word == W_WDOG) begin
                sel = SEL_WDOG;
            end else if (word == W_IEN) begin
                sel = SEL_IEN;
            end
        end
    end

    always_comb begin
        cnt_wr   = wr_i && (sel == SEL_COUNT);
        stat_wr  = wr_i && (sel == SEL_STATUS);
        ien_wr   = wr_i && (sel == SEL_IEN);
        wd_wr    = wr_i && (sel == SEL_WDOG);
        match_wr = '0;
        if (wr_i && (sel == SEL_MATCH)) begin
            match_wr[idx] = 1'b1;
        end
    end

    // ---------------- datapath ----------------
    omt_counter #(.DW(DW)) u_counter (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick_i),
        .load_i     (cnt_wr),
        .load_val_i (wdata_i),
        .cnt_o      (cnt),
        .nxt_o      (cnt_nxt),
        .adv_o      (cnt_adv)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        omt_channel #(.DW(DW)) u_chan (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .wr_i    (match_wr[g]),
            .wdata_i (wdata_i),
            .adv_i   (cnt_adv),
            .nxt_i   (cnt_nxt),
            .match_o (match_q[g]),
            .hit_o   (hit[g])
        );
    end

    omt_ctrl #(
        .NCH   (NCH),
        .IEN_W (IEN_W),
        .WD_CH (WD_CH)
    ) u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .hit_i     (hit),
        .stat_wr_i (stat_wr),
        .ien_wr_i  (ien_wr),
        .wd_wr_i   (wd_wr),
        .wdata_i   (wdata_i[IEN_W-1:0]),
        .status_o  (status),
        .ien_o     (ien),
        .wd_en_o   (wd_en),
        .rst_req_o (rst_req_o)
    );

    // ---------------- read mux ----------------
    always_comb begin
        rd_val = '0;
        unique case (sel)
            SEL_MATCH:  rd_val = match_q[idx];
            SEL_COUNT:  rd_val = cnt;
            SEL_STATUS: rd_val[NCH-1:0] = status;
            SEL_WDOG:   rd_val[0] = wd_en;
            SEL_IEN:    rd_val[IEN_W-1:0] = ien;
            default:    rd_val = '0;
        endcase
        rdata_o = rd_i ? rd_val : '0;
    end

    assign irq_o = status;

endmodule

// File: rtl/omt_chk.sv
module omt_chk #(
    parameter int unsigned DW    = 32,
    parameter int unsigned NCH   = 4,
    parameter int unsigned AW    = 12,
    parameter int unsigned IEN_W = 12
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             tick_i,
    input logic [AW-1:0]    addr_i,
    input logic [DW-1:0]    wdata_i,
    input logic             rd_i,
    input logic [DW-1:0]    rdata_o,
    input logic [NCH-1:0]   irq_o,
    input logic             rst_req_o,
    input logic             cnt_wr,
    input logic             stat_wr,
    input logic [DW-1:0]    cnt,
    input logic [NCH-1:0]   hit,
    input logic [IEN_W-1:0] ien,
    input logic             wd_en
);

    localparam logic [AW-1:0] A_IEN = AW'(omt_pkg::OFF_IEN);
    localparam logic [DW-1:0] ONE   = {{(DW-1){1'b0}}, 1'b1};

    // R2
    cnt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_wr |=> cnt == $past(wdata_i));

    // R2
    cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cnt_wr && !tick_i) |=> $stable(cnt));

    // R2
    cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cnt_wr && tick_i) |=> cnt == $past(cnt) + ONE);

    // R4
    irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(|irq_o) |-> ((irq_o & ~$past(irq_o) & ~$past(ien[NCH-1:0])) == '0));

    // R4
    irq_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(hit & ien[NCH-1:0])) |=>
            ((irq_o & $past(hit & ien[NCH-1:0])) == $past(hit & ien[NCH-1:0])));

    // R5
    w1c_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat_wr |=> ((irq_o & $past(wdata_i[NCH-1:0] & ~hit)) == '0));

    // R6
    ien_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && addr_i == A_IEN) |-> rdata_o[DW-1:IEN_W] == '0);

    // R7
    wd_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wd_en |=> wd_en);

    // R8
    rst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_o |=> rst_req_o);

    // R8
    rst_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_req_o) |-> $past(wd_en && hit[NCH-1]));

    // R9
    idle_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_i |-> rdata_o == '0);

endmodule

bind os_match_timer omt_chk #(
    .DW    (DW),
    .NCH   (NCH),
    .AW    (AW),
    .IEN_W (IEN_W)
) u_omt_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rd_i      (rd_i),
    .rdata_o   (rdata_o),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o),
    .cnt_wr    (cnt_wr),
    .stat_wr   (stat_wr),
    .cnt       (cnt),
    .hit       (hit),
    .ien       (ien),
    .wd_en     (wd_en)
);

// File: tb/os_match_timer_tb_top.sv
module os_match_timer_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [31:0] rdata;
    logic [3:0]  irq;
    logic        rst_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    os_match_timer dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .tick_i    (tick),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .wr_i      (wr),
        .rd_i      (rd),
        .rdata_o   (rdata),
        .irq_o     (irq),
        .rst_req_o (rst_req)
    );

    // behavioural reference state
    logic [31:0] m_cnt;
    logic [31:0] m_match [4];
    logic [3:0]  m_stat;
    logic [11:0] m_ien;
    logic        m_wd;
    logic        m_rreq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    string tag = "";

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = '0; m_stat = '0; m_ien = '0; m_wd = 1'b0; m_rreq = 1'b0;
        for (int i = 0; i < 4; i++) m_match[i] = '0;
    endtask

    function automatic logic [31:0] m_read(input logic [11:0] a);
        case (a)
            12'h000: return m_match[0];
            12'h004: return m_match[1];
            12'h008: return m_match[2];
            12'h00c: return m_match[3];
            12'h010: return m_cnt;
            12'h014: return {28'd0, m_stat};
            12'h018: return {31'd0, m_wd};
            12'h01c: return {20'd0, m_ien};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string req_of(input logic [11:0] a);
        if (tag != "") return tag;
        case (a)
            12'h000, 12'h004, 12'h008, 12'h00c: return "R3 compare read";
            12'h010: return "R2 counter read";
            12'h014: return "R5 status read";
            12'h018: return "R7 watchdog enable read";
            12'h01c: return "R6 enable read";
            default: return "R9 unmapped read";
        endcase
    endfunction

    task automatic model_step(input bit w, input bit t, input logic [11:0] a, input logic [31:0] d);
        logic [3:0] h;
        logic [31:0] nx;
        bit ld;
        ld = w && (a == 12'h010);
        nx = m_cnt + 32'd1;
        for (int i = 0; i < 4; i++) h[i] = t && !ld && (nx == m_match[i]);
        if (m_wd && h[3]) m_rreq = 1'b1;
        m_stat = (m_stat & ~((w && a == 12'h014) ? d[3:0] : 4'h0)) | (h & m_ien[3:0]);
        if (ld) m_cnt = d;
        else if (t) m_cnt = nx;
        if (w) begin
            case (a)
                12'h000: m_match[0] = d;
                12'h004: m_match[1] = d;
                12'h008: m_match[2] = d;
                12'h00c: m_match[3] = d;
                12'h018: if (d[0]) m_wd = 1'b1;
                12'h01c: m_ien = d[11:0];
                default: ;
            endcase
        end
    endtask

    // one bus cycle: drive, compare, clock, advance model
    task automatic cyc(input bit w, input bit r, input bit t, input logic [11:0] a, input logic [31:0] d);
        logic [31:0] exp;
        @(negedge clk);
        wr = w; rd = r; tick = t; addr = a; wdata = d;
        #1;
        exp = r ? m_read(a) : 32'd0;
        check(rdata == exp, r ? req_of(a) : "R9 idle rdata", rdata, exp);
        check(irq == m_stat, "R4/R5 irq lines", {28'd0, irq}, {28'd0, m_stat});
        check(rst_req == m_rreq, "R8 reset request", {31'd0, rst_req}, {31'd0, m_rreq});
        @(posedge clk);
        model_step(w, t, a, d);
    endtask

    task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
        cyc(1'b1, 1'b0, 1'b0, a, d);
    endtask

    task automatic rd_reg(input logic [11:0] a);
        cyc(1'b0, 1'b1, 1'b0, a, 32'd0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b1, 1'b1, 12'h014, 32'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr = 0; rd = 0; tick = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R1 reset state";
        for (int i = 0; i < 9; i++) rd_reg(12'(i * 4));
        tag = "";
    endtask

    initial begin
        model_reset();
        do_reset();

        // R3 compare registers and R6 enable masking
        wr_reg(12'h000, 32'd5);
        wr_reg(12'h008, 32'hdead_beef);
        rd_reg(12'h000);
        rd_reg(12'h008);
        wr_reg(12'h01c, 32'hffff_fff1);
        rd_reg(12'h01c);

        // R4 channel 0 fires at count 5; R2 counting
        wr_reg(12'h010, 32'd0);
        ticks(7);
        rd_reg(12'h010);
        // R2 hold without tick
        cyc(1'b0, 1'b1, 1'b0, 12'h010, 32'd0);
        cyc(1'b0, 1'b1, 1'b0, 12'h010, 32'd0);
        // R5 writing zero keeps, writing one clears
        wr_reg(12'h014, 32'h0000_000e);
        rd_reg(12'h014);
        wr_reg(12'h014, 32'h0000_0001);
        rd_reg(12'h014);

        // R4 disabled channel 1 across wrap: no event
        wr_reg(12'h004, 32'd0);
        wr_reg(12'h010, 32'hffff_fffe);
        ticks(3);
        // R4 enabled channel 1 across wrap
        wr_reg(12'h01c, 32'h0000_000b);
        wr_reg(12'h010, 32'hffff_fffe);
        ticks(3);
        // R2 load beats tick in the same cycle
        cyc(1'b1, 1'b0, 1'b1, 12'h010, 32'h0000_0100);
        rd_reg(12'h010);

        // R5 event and clear in the same cycle: event wins
        wr_reg(12'h000, 32'h0000_0101);
        cyc(1'b1, 1'b0, 1'b1, 12'h014, 32'h0000_000f);
        rd_reg(12'h014);
        wr_reg(12'h014, 32'h0000_000f);

        // R9 unmapped and unaligned accesses
        wr_reg(12'h020, 32'hffff_ffff);
        wr_reg(12'h002, 32'hffff_ffff);
        rd_reg(12'h020);
        rd_reg(12'h001);
        rd_reg(12'h7fc);
        rd_reg(12'h000);

        // R8 channel-3 event without watchdog: interrupt only
        wr_reg(12'h00c, m_cnt + 32'd2);
        ticks(3);
        wr_reg(12'h014, 32'h0000_0008);

        // random traffic (watchdog stays off)
        for (int k = 0; k < 400; k++) begin
            int op;
            op = int'($urandom % 8);
            case (op)
                0: wr_reg(12'(($urandom % 4) * 4), m_cnt + ($urandom % 6));
                1: wr_reg(12'h014, $urandom);
                2: wr_reg(12'h01c, $urandom);
                3: rd_reg(12'($urandom % 40));
                4: cyc(1'b1, 1'b0, ($urandom % 2) == 1, 12'h010, m_cnt - ($urandom % 4));
                default: cyc(1'b0, 1'b1, 1'b1, 12'(($urandom % 8) * 4), 32'd0);
            endcase
        end

        // R7 one-way watchdog enable, R8 reset request
        wr_reg(12'h01c, 32'h0000_0000);
        wr_reg(12'h018, 32'h0000_0000);
        rd_reg(12'h018);
        wr_reg(12'h018, 32'h0000_0001);
        wr_reg(12'h018, 32'h0000_0000);
        rd_reg(12'h018);
        wr_reg(12'h00c, m_cnt + 32'd3);
        ticks(5);
        // stays high
        ticks(2);
        check(rst_req == 1'b1, "R8 reset request held", {31'd0, rst_req}, 32'd1);

        // R1 reset clears everything including the sticky bits
        do_reset();
        ticks(2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R2 progress actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule